// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block moves a device-side byte count to or from system memory by following a table of region descriptors that software has placed in memory. A command gives the table's base address, the number of device bytes to move and the direction. The walker reads one 8-byte descriptor at a time through a request/response read port. From each descriptor it takes a region base address, a byte count and an end-of-table flag. It then issues transfer requests, each carrying a memory address, a byte length and a direction, through a valid/ready port.

Each transfer is as long as the smaller of two amounts: the bytes left in the current region and the device bytes still outstanding. The walk ends in one of two ways, and a one-cycle done pulse with a status code reports which. Either every device byte has moved, or the table ran out while device bytes were still outstanding. The table runs out when the last descriptor is used up, or when the walk has stepped one 4 KiB page past the table base.

Top module: `sg_walker`

## Requirements
- R1: A synchronous reset, asserted at any time, returns the walker to idle. On the cycle after reset no descriptor request, no transfer request and no done pulse is presented.
- R2: Descriptor fetches go out at the table base, which must be 8-byte aligned, and then at base+8, base+16 and so on, one per region. Response data[31:0] is the region base and data[63:32] is the control word.
- R3: The region byte count is control[15:0] with bit 0 treated as zero. A resulting count of zero means 65536 bytes.
- R4: Control bit 31 marks the last descriptor. Once that region is used up with device bytes still outstanding, the walker fetches nothing more and pulses done with status 2'b10.
- R5: Once a region is used up, the walker also stops with status 2'b10 if the descriptor pointer has moved 4096 or more bytes past the table base. This caps a table at 512 descriptors.
- R6: Each transfer length is min(bytes left in the region, device bytes outstanding). Its address is the region base plus the bytes already moved from that region.
- R7: When the outstanding device count reaches zero, done pulses with status 2'b01 and no further request follows. A command with a device count of zero completes this way without any fetch.
- R8: xferWrite is 1 for device-to-memory commands (toMemory=1) and 0 for memory-to-device commands.
- R9: A new command discards the region address, region length and last flag left by the previous command.
- R10: A descriptor or transfer request that is not accepted keeps its valid, address and length unchanged until ready.
- R11: done is high for exactly one cycle per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a command; sampled only while idle |
| tableBase | input | 32 | Descriptor table base address, 8-byte aligned |
| devBytes | input | 32 | Device bytes to move |
| toMemory | input | 1 | 1: device-to-memory (writes), 0: memory-to-device (reads) |
| descReqValid | output | 1 | Descriptor fetch request |
| descReqReady | input | 1 | Fetch request accepted |
| descReqAddr | output | 32 | Descriptor address |
| descRspValid | input | 1 | Descriptor data valid |
| descRspData | input | 64 | Descriptor: [31:0] region base, [63:32] control |
| xferValid | output | 1 | Transfer request valid |
| xferReady | input | 1 | Transfer request accepted |
| xferAddr | output | 32 | Transfer memory address |
| xferLen | output | 17 | Transfer length in bytes (1 to 65536) |
| xferWrite | output | 1 | 1 = memory write, 0 = memory read |
| done | output | 1 | One-cycle end-of-command pulse |
| doneStatus | output | 2 | 2'b01 all bytes moved, 2'b10 table exhausted |

## Verification
The bench goes after the following corner cases:
- Odd byte counts and a zero byte count. A walker that kept bit 0, or that read zero as zero, would issue a transfer of the wrong length, or none at all.
- A device count that stops part-way through a region. A walker that ignored it would over-run the transfer and report the wrong status.
- A table with no end flag. A walker without the 4 KiB stop would fetch past descriptor 512, and the bench counts those fetches.
- A command that follows a partly used region. It shows whether leftover region state leaks into the next command's first transfer.
- Zero device bytes. This must complete without touching memory.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_FETCH,
    ST_WAIT,
    ST_XFER
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;
    logic loadDesc;
    logic consume;
  } dpCtrl_t;

  localparam logic [1:0] DONE_OK        = 2'b01;
  localparam logic [1:0] DONE_EXHAUSTED = 2'b10;
endpackage

// File: rtl/sgw_datapath.sv
module sgw_datapath
  import sgw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int DESC_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           ctrl,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [CNT_W-1:0]  devBytes,
  input  logic              toMemory,
  input  logic [63:0]       descData,
  output logic [ADDR_W-1:0] descPtr,
  output logic [ADDR_W-1:0] regionAddr,
  output logic [16:0]       chunkLen,
  output logic              dirWrite,
  output logic              pendZero,
  output logic              regionEmpty,
  output logic              lastSeen,
  output logic              pageHit
);
  localparam int LEN_W = 17;

  logic [ADDR_W-1:0] baseQ;
  logic [LEN_W-1:0]  regionLeft;
  logic [CNT_W-1:0]  pending;
  logic [15:0]       rawLen;
  logic [LEN_W-1:0]  decodedLen;
  logic [CNT_W-1:0]  leftWide;
  logic              unusedCtrl;

  assign unusedCtrl = ^{descData[62:48], descData[32]};

  // length field with bit 0 dropped; zero encodes a full 64 KiB region
  assign rawLen     = {descData[47:33], 1'b0};
  assign decodedLen = (rawLen == 16'd0) ? LEN_W'(65536) : {1'b0, rawLen};

  assign leftWide    = CNT_W'(regionLeft);
  assign chunkLen    = (pending < leftWide) ? pending[LEN_W-1:0] : regionLeft;
  assign pendZero    = (pending == '0);
  assign regionEmpty = (regionLeft == '0);
  assign pageHit     = ((descPtr - baseQ) >= ADDR_W'(PAGE_BYTES));

  always_ff @(posedge clk) begin
    if (rst) begin
      baseQ      <= '0;
      descPtr    <= '0;
      regionAddr <= '0;
      regionLeft <= '0;
      lastSeen   <= 1'b0;
      pending    <= '0;
      dirWrite   <= 1'b0;
    end else if (ctrl.loadCmd) begin
      baseQ      <= tableBase;
      descPtr    <= tableBase;
      regionAddr <= '0;
      regionLeft <= '0;
      lastSeen   <= 1'b0;
      pending    <= devBytes;
      dirWrite   <= toMemory;
    end else if (ctrl.loadDesc) begin
      regionAddr <= descData[ADDR_W-1:0];
      regionLeft <= decodedLen;
      lastSeen   <= descData[63];
      descPtr    <= descPtr + ADDR_W'(DESC_BYTES);
    end else if (ctrl.consume) begin
      regionAddr <= regionAddr + ADDR_W'(chunkLen);
      regionLeft <= regionLeft - chunkLen;
      pending    <= pending - CNT_W'(chunkLen);
    end
  end
endmodule

// File: rtl/sgw_ctrl.sv
module sgw_ctrl
  import sgw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       descReqReady,
  input  logic       descRspValid,
  input  logic       xferReady,
  input  logic       pendZero,
  input  logic       regionEmpty,
  input  logic       lastSeen,
  input  logic       pageHit,
  output dpCtrl_t    ctrl,
  output logic       descReqValid,
  output logic       xferValid,
  output logic       done,
  output logic [1:0] doneStatus
);
  walkState_e state, nextState;
  logic       finish;
  logic [1:0] finishCode;

  always_comb begin
    nextState  = state;
    finish     = 1'b0;
    finishCode = DONE_OK;
    unique case (state)
      ST_IDLE:  if (start) nextState = ST_EVAL;
      ST_EVAL: begin
        if (pendZero) begin
          nextState = ST_IDLE;
          finish    = 1'b1;
        end else if (regionEmpty) begin
          if (lastSeen || pageHit) begin
            nextState  = ST_IDLE;
            finish     = 1'b1;
            finishCode = DONE_EXHAUSTED;
          end else begin
            nextState = ST_FETCH;
          end
        end else begin
          nextState = ST_XFER;
        end
      end
      ST_FETCH: if (descReqReady) nextState = ST_WAIT;
      ST_WAIT:  if (descRspValid) nextState = ST_EVAL;
      ST_XFER:  if (xferReady) nextState = ST_EVAL;
      default:  nextState = ST_IDLE;
    endcase
  end

  assign ctrl.loadCmd  = (state == ST_IDLE) && start;
  assign ctrl.loadDesc = (state == ST_WAIT) && descRspValid;
  assign ctrl.consume  = (state == ST_XFER) && xferReady;
  assign descReqValid  = (state == ST_FETCH);
  assign xferValid     = (state == ST_XFER);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      done       <= 1'b0;
      doneStatus <= 2'b00;
    end else begin
      state <= nextState;
      done  <= finish;
      if (finish) doneStatus <= finishCode;
    end
  end
endmodule

// File: rtl/sg_walker.sv
module sg_walker
  import sgw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int DESC_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [CNT_W-1:0]  devBytes,
  input  logic              toMemory,
  output logic              descReqValid,
  input  logic              descReqReady,
  output logic [ADDR_W-1:0] descReqAddr,
  input  logic              descRspValid,
  input  logic [63:0]       descRspData,
  output logic              xferValid,
  input  logic              xferReady,
  output logic [ADDR_W-1:0] xferAddr,
  output logic [16:0]       xferLen,
  output logic              xferWrite,
  output logic              done,
  output logic [1:0]        doneStatus
);
  dpCtrl_t ctrl;
  logic    pendZero, regionEmpty, lastSeen, pageHit;

  sgw_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .descReqReady (descReqReady),
    .descRspValid (descRspValid),
    .xferReady    (xferReady),
    .pendZero     (pendZero),
    .regionEmpty  (regionEmpty),
    .lastSeen     (lastSeen),
    .pageHit      (pageHit),
    .ctrl         (ctrl),
    .descReqValid (descReqValid),
    .xferValid    (xferValid),
    .done         (done),
    .doneStatus   (doneStatus)
  );

  sgw_datapath #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .PAGE_BYTES (PAGE_BYTES),
    .DESC_BYTES (DESC_BYTES)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .ctrl        (ctrl),
    .tableBase   (tableBase),
    .devBytes    (devBytes),
    .toMemory    (toMemory),
    .descData    (descRspData),
    .descPtr     (descReqAddr),
    .regionAddr  (xferAddr),
    .chunkLen    (xferLen),
    .dirWrite    (xferWrite),
    .pendZero    (pendZero),
    .regionEmpty (regionEmpty),
    .lastSeen    (lastSeen),
    .pageHit     (pageHit)
  );
endmodule

// File: rtl/sg_walker_chk.sv
module sg_walker_chk
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              descReqValid,
  input logic              descReqReady,
  input logic [ADDR_W-1:0] descReqAddr,
  input logic              xferValid,
  input logic              xferReady,
  input logic [ADDR_W-1:0] xferAddr,
  input logic [16:0]       xferLen,
  input logic              xferWrite,
  input logic              done,
  input logic [1:0]        doneStatus
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!descReqValid && !xferValid && !done));

  assert_fetch_align_R2: assert property (@(posedge clk) disable iff (rst)
    descReqValid |-> (descReqAddr[2:0] == 3'b000));

  assert_one_request_R2: assert property (@(posedge clk) disable iff (rst)
    !(descReqValid && xferValid));

  assert_len_range_R6: assert property (@(posedge clk) disable iff (rst)
    xferValid |-> (xferLen != 17'd0 && xferLen <= 17'd65536));

  assert_status_code_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (doneStatus == DONE_OK || doneStatus == DONE_EXHAUSTED));

  assert_dir_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (xferValid && $past(xferValid)) |-> $stable(xferWrite));

  assert_fetch_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (descReqValid && !descReqReady) |=> (descReqValid && $stable(descReqAddr)));

  assert_xfer_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (xferValid && !xferReady) |=> (xferValid && $stable(xferAddr) && $stable(xferLen)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind sg_walker sg_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .descReqValid (descReqValid),
  .descReqReady (descReqReady),
  .descReqAddr  (descReqAddr),
  .xferValid    (xferValid),
  .xferReady    (xferReady),
  .xferAddr     (xferAddr),
  .xferLen      (xferLen),
  .xferWrite    (xferWrite),
  .done         (done),
  .doneStatus   (doneStatus)
);

// File: tb/sg_walker_tb.sv
module sg_walker_tb;
  localparam int TBL = 600;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] tableBase = '0;
  logic [31:0] devBytes = '0;
  logic        toMemory = 1'b0;
  logic        descReqValid, descReqReady = 1'b0;
  logic [31:0] descReqAddr;
  logic        descRspValid = 1'b0;
  logic [63:0] descRspData = '0;
  logic        xferValid, xferReady = 1'b0;
  logic [31:0] xferAddr;
  logic [16:0] xferLen;
  logic        xferWrite;
  logic        done;
  logic [1:0]  doneStatus;

  always #10 clk = ~clk;

  sg_walker u_dut (
    .clk(clk), .rst(rst), .start(start), .tableBase(tableBase),
    .devBytes(devBytes), .toMemory(toMemory),
    .descReqValid(descReqValid), .descReqReady(descReqReady), .descReqAddr(descReqAddr),
    .descRspValid(descRspValid), .descRspData(descRspData),
    .xferValid(xferValid), .xferReady(xferReady), .xferAddr(xferAddr),
    .xferLen(xferLen), .xferWrite(xferWrite), .done(done), .doneStatus(doneStatus)
  );

  logic [31:0] descLo [TBL];
  logic [31:0] descHi [TBL];
  logic [31:0] expAddr [TBL];
  longint      expLen [TBL];
  int          expCount, expFetch;
  logic [1:0]  expStatus;
  int          nChecks = 0;
  int          nFails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // reference walk computed from the requirements
  task automatic model(input longint dev);
    longint pend = dev;
    longint left = 0;
    longint ch;
    logic [31:0] raddr = '0;
    int ofs = 0;
    bit last = 0;
    int idx;
    expCount = 0;
    expFetch = 0;
    while (1) begin
      if (pend == 0) begin expStatus = 2'b01; break; end
      if (left == 0) begin
        if (last || ofs >= 4096) begin expStatus = 2'b10; break; end
        idx   = ofs / 8;
        raddr = descLo[idx];
        left  = longint'(descHi[idx] & 32'h0000_fffe);
        if (left == 0) left = 65536;
        last  = descHi[idx][31];
        ofs  += 8;
        expFetch++;
      end
      ch = (pend < left) ? pend : left;
      expAddr[expCount] = raddr;
      expLen[expCount]  = ch;
      expCount++;
      raddr += 32'(ch);
      left  -= ch;
      pend  -= ch;
    end
  endtask

  task automatic runCmd(input logic [31:0] base, input logic [31:0] dev,
                        input bit toMem, input string req);
    int obsChunks = 0;
    int obsFetch = 0;
    int doneCount = 0;
    int rspWait = -1;
    int rspIdx = 0;
    int tail = 0;
    int cyc = 0;
    logic [1:0] gotStatus = 2'b00;
    model(longint'(dev));
    @(negedge clk);
    tableBase = base; devBytes = dev; toMemory = toMem; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (tail < 4) begin
      @(negedge clk);
      cyc++;
      if (cyc > 30000) begin
        chk(1'b0, req, "watchdog expired", cyc, 30000);
        break;
      end
      descRspValid = 1'b0;
      if (rspWait == 0) begin
        descRspValid = 1'b1;
        descRspData  = {descHi[rspIdx], descLo[rspIdx]};
      end
      if (rspWait >= 0) rspWait--;
      if (done) begin
        doneCount++;
        gotStatus = doneStatus;
      end
      if (doneCount > 0) begin
        tail++;
        chk(!descReqValid && !xferValid, "R7", "request after done",
            {descReqValid, xferValid}, 0);
      end
      descReqReady = ($urandom % 3) != 0;
      if (descReqValid && descReqReady) begin
        chk(descReqAddr == base + 32'(obsFetch * 8), "R2", "fetch address",
            descReqAddr, base + 32'(obsFetch * 8));
        rspIdx  = obsFetch;
        rspWait = $urandom % 3;
        obsFetch++;
      end
      xferReady = ($urandom % 3) != 0;
      if (xferValid && xferReady) begin
        if (obsChunks < expCount) begin
          chk(xferAddr == expAddr[obsChunks], "R6", "chunk address",
              xferAddr, expAddr[obsChunks]);
          chk(longint'(xferLen) == expLen[obsChunks], "R3/R6", "chunk length",
              xferLen, expLen[obsChunks]);
        end
        chk(xferWrite == toMem, "R8", "direction", xferWrite, toMem);
        obsChunks++;
      end
    end
    descReqReady = 1'b0; xferReady = 1'b0; descRspValid = 1'b0;
    chk(obsChunks == expCount, req, "chunk count", obsChunks, expCount);
    chk(obsFetch == expFetch, req, "fetch count", obsFetch, expFetch);
    chk(gotStatus == expStatus, req, "done status", gotStatus, expStatus);
    chk(doneCount == 1, "R11", "done pulses", doneCount, 1);
  endtask

  initial begin
    int n;
    longint total;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < TBL; i++) begin descLo[i] = '0; descHi[i] = 32'h8000_0002; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!descReqValid && !xferValid && !done, "R1", "idle after reset",
        {descReqValid, xferValid, done}, 0);

    // single last region, exact fit
    descLo[0] = 32'h1000_0000; descHi[0] = 32'h8000_0100;
    runCmd(32'h0002_0000, 32'h100, 1'b1, "R7");

    // odd count drops bit 0; last flag ends with bytes pending
    descLo[0] = 32'h2000_0010; descHi[0] = 32'h0000_0013;
    descLo[1] = 32'h3000_0000; descHi[1] = 32'h8000_0021;
    runCmd(32'h0004_0008, 32'h1000, 1'b0, "R4");

    // zero count means 64 KiB
    descLo[0] = 32'h4000_0000; descHi[0] = 32'h0000_0000;
    descLo[1] = 32'h5000_0000; descHi[1] = 32'h8001_0000;
    runCmd(32'h0000_0100, 32'h0002_0000, 1'b1, "R3");

    // device count ends mid-region, then a fresh command must not reuse it
    descLo[0] = 32'h6000_0000; descHi[0] = 32'h8000_0400;
    runCmd(32'h0000_0200, 32'h40, 1'b1, "R6");
    descLo[0] = 32'h7000_0000; descHi[0] = 32'h8000_0010;
    runCmd(32'h0000_0200, 32'h10, 1'b0, "R9");

    // zero device bytes: no fetch
    runCmd(32'h0000_0300, 32'h0, 1'b1, "R7");

    // no end flag: page limit stops after 512 descriptors
    for (int i = 0; i < TBL; i++) begin descLo[i] = 32'h0800_0000 + 32'(i * 16); descHi[i] = 32'h0000_0002; end
    runCmd(32'h0010_0000, 32'h0001_0000, 1'b1, "R5");
    chk(expFetch == 512, "R5", "model fetch cap", expFetch, 512);

    // reset mid-command
    descLo[0] = 32'h0900_0000; descHi[0] = 32'h8000_0100;
    @(negedge clk);
    tableBase = 32'h0000_0800; devBytes = 32'h100; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(!descReqValid && !xferValid && !done, "R1", "idle after mid-run reset",
        {descReqValid, xferValid, done}, 0);
    repeat (3) begin
      @(negedge clk);
      chk(!descReqValid && !xferValid && !done, "R1", "stays idle",
          {descReqValid, xferValid, done}, 0);
    end

    // constrained random tables
    for (int t = 0; t < 40; t++) begin
      n = 1 + $urandom % 6;
      total = 0;
      for (int i = 0; i < TBL; i++) begin
        descLo[i] = $urandom;
        descHi[i] = ($urandom & 32'h7fff_ffff) | ((i >= n - 1) ? 32'h8000_0000 : 32'h0);
        if ($urandom % 8 == 0) descHi[i] = descHi[i] & 32'hffff_0001;
        if (i < n) begin
          if ((descHi[i] & 32'hfffe) == 0) total += 65536;
          else total += longint'(descHi[i] & 32'hfffe);
        end
      end
      runCmd(32'(($urandom % 4096) * 8), 32'($urandom % (total + 2000)),
             1'($urandom), "R6");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule